// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates six interrupt sources for a small processor core: two external request pins, the overflow of two timers, a serial port request and a timer 2 request. It holds the enable, priority and trigger-type registers, keeps the edge flags for the external pins and the overflow flags of timers 0 and 1, and presents the winning request to the CPU as a 16-bit vector address together with its priority level.

The CPU writes configuration through a simple write port, takes a presented request with a one-cycle acknowledge pulse and signals the end of a service routine with a return pulse. Two in-service bits, one per level, give two-deep nesting. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine. On acknowledge the block clears the flags that hardware owns. The serial and timer 2 requests are held by their sources and stay asserted until software clears them there.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every enable, priority and type bit is 0, both in-service bits are 0, all four held flags are 0 and no request is presented.
- R2: While enable bit 7 (global gate) is 0 no request is presented, whatever the other bits hold.
- R3: Source n is a candidate only when its enable bit n is 1, with n = 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. The same bit numbers are used in the priority register.
- R4: A candidate whose priority bit is 1 belongs to the high level and wins over any low-level candidate, whatever the poll order.
- R5: Among candidates of the same level the lowest source number wins.
- R6: The vector is 0003H + 8 x source number: 0003H, 000BH, 0013H, 001BH, 0023H, 002BH.
- R7: Type bit 0 controls external 0 and type bit 1 controls external 1. With the bit at 0 the request follows the active-low pin in the same cycle. With the bit at 1 a high-to-low transition sets a held flag that stays set after the pin returns high.
- R8: Acknowledge clears the held flag of an edge-mode external source and the overflow flag of timer 0 or 1. It clears nothing for a level-mode external source, the serial source or timer 2. Flag output bits: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1.
- R9: While the high in-service bit is set no request is presented. While only the low bit is set only high-level requests are presented.
- R10: A return pulse clears the high in-service bit if it is set, and otherwise the low bit.
- R11: An acknowledge while no request is presented changes neither in-service bits nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 type |
| cfg_wdata | input | 8 | Write data |
| ext_n | input | 2 | Active-low external request pins (bit 0 external 0) |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| ser_req | input | 1 | Serial request level, held by its source |
| t2_req | input | 1 | Timer 2 request level, held by its source |
| ack | input | 1 | CPU takes the presented request |
| reti | input | 1 | End of the current service routine |
| irq_valid | output | 1 | A request is presented |
| irq_vector | output | 16 | Vector address of the presented request |
| irq_level | output | 1 | Level of the presented request (1 high) |
| in_service | output | 2 | In-service bits, bit 1 high level |
| flags | output | 4 | Held flags as listed in R8 |

## Verification
A wrong in-service bit shows at once as a request that is withheld when it should be presented, or presented when it should be blocked, in the cycle after the acknowledge or return that corrupted it. A held flag that is not cleared, or is cleared when it should not be, shows on the flag outputs one cycle after acknowledge and as a repeated vector after the return. Arbitration errors show in the same cycle as a wrong vector or level, so the random phase compares every presented vector against a model of the enables, priorities and poll order.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC       = 6;
    localparam int NEXT       = 2;
    localparam int NLVL       = 2;
    localparam int IDXW       = $clog2(NSRC);
    localparam int VECW       = 16;
    localparam logic [VECW-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_STRIDE = 8;
    localparam int GATE_BIT   = 7;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO   = 2'd1,
        SEL_TYPE   = 2'd2
    } cfg_sel_e;

    typedef struct packed {
        logic            valid;
        logic            level;
        logic [IDXW-1:0] idx;
    } pick_t;

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_BASE + VECW'(idx) * VECW'(VEC_STRIDE);
    endfunction

    function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      sel,
    input  logic [7:0]      wdata,
    output logic            gate,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] pri,
    output logic [NEXT-1:0] typ
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= 1'b0;
            en   <= '0;
            pri  <= '0;
            typ  <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ENABLE: begin
                    gate <= wdata[GATE_BIT];
                    en   <= wdata[NSRC-1:0];
                end
                SEL_PRIO: pri <= wdata[NSRC-1:0];
                SEL_TYPE: typ <= wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] typ,
    input  logic [1:0]      tmr_ovf,
    input  logic            ser_req,
    input  logic            t2_req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] req,
    output logic [3:0]      flags
);
    logic [NEXT-1:0] pin_q;
    logic [NEXT-1:0] edge_q;
    logic [NEXT-1:0] ext_req;
    logic [1:0]      tf_q;

    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_ext
            localparam int SRC = 2 * g;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pin_q[g]  <= 1'b1;
                    edge_q[g] <= 1'b0;
                end else begin
                    pin_q[g] <= ext_n[g];
                    if (typ[g] && pin_q[g] && !ext_n[g])
                        edge_q[g] <= 1'b1;
                    else if (clr[SRC] && typ[g])
                        edge_q[g] <= 1'b0;
                end
            end
            assign ext_req[g] = typ[g] ? edge_q[g] : !ext_n[g];
        end

        for (g = 0; g < 2; g++) begin : g_tmr
            localparam int SRC = 2 * g + 1;
            always_ff @(posedge clk) begin
                if (rst)
                    tf_q[g] <= 1'b0;
                else if (tmr_ovf[g])
                    tf_q[g] <= 1'b1;
                else if (clr[SRC])
                    tf_q[g] <= 1'b0;
            end
            a_r8_tf_hw_clear: assert property (@(posedge clk) disable iff (rst)
                (clr[SRC] && !tmr_ovf[g]) |=> !tf_q[g]);
        end
    endgenerate

    a_r7_edge_held: assert property (@(posedge clk) disable iff (rst)
        (typ[0] && edge_q[0] && !clr[0] && $stable(typ[0])) |=> edge_q[0]);

    assign req   = {t2_req, ser_req, tf_q[1], ext_req[1], tf_q[0], ext_req[0]};
    assign flags = {tf_q[1], edge_q[1], tf_q[0], edge_q[0]};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic            gate,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pri,
    input  logic [NSRC-1:0] req,
    input  logic [NLVL-1:0] svc,
    output pick_t           pick
);
    logic [NSRC-1:0] cand;
    logic [NSRC-1:0] hi_c;
    logic [NSRC-1:0] lo_c;

    always_comb begin
        cand = req & en & {NSRC{gate}};
        hi_c = cand & pri;
        lo_c = cand & ~pri;
        pick = '0;
        if (svc[1]) begin
            pick = '0;
        end else if (|hi_c) begin
            pick.valid = 1'b1;
            pick.level = 1'b1;
            pick.idx   = first_set(hi_c);
        end else if (!svc[0] && |lo_c) begin
            pick.valid = 1'b1;
            pick.level = 1'b0;
            pick.idx   = first_set(lo_c);
        end
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            take_lvl,
    input  logic            reti,
    output logic [NLVL-1:0] svc
);
    logic [NLVL-1:0] nxt;

    always_comb begin
        nxt = svc;
        if (reti) begin
            if (nxt[1]) nxt[1] = 1'b0;
            else        nxt[0] = 1'b0;
        end
        if (take) nxt[take_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) svc <= '0;
        else     svc <= nxt;
    end

    a_r10_reti_top_first: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && svc[1]) |=> (!svc[1] && svc[0] == $past(svc[0])));
    a_r10_reti_low: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && !svc[1]) |=> (svc == 2'b00));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic [1:0]  ext_n,
    input  logic [1:0]  tmr_ovf,
    input  logic        ser_req,
    input  logic        t2_req,
    input  logic        ack,
    input  logic        reti,
    output logic        irq_valid,
    output logic [15:0] irq_vector,
    output logic        irq_level,
    output logic [1:0]  in_service,
    output logic [3:0]  flags
);
    logic            gate;
    logic [NSRC-1:0] en, pri, req, clr;
    logic [NEXT-1:0] typ;
    pick_t           pick;
    logic            take;

    irq_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .gate(gate), .en(en), .pri(pri), .typ(typ)
    );

    irq_flags u_flags (
        .clk(clk), .rst(rst), .ext_n(ext_n), .typ(typ), .tmr_ovf(tmr_ovf),
        .ser_req(ser_req), .t2_req(t2_req), .clr(clr), .req(req), .flags(flags)
    );

    irq_arbiter u_arb (
        .gate(gate), .en(en), .pri(pri), .req(req), .svc(in_service), .pick(pick)
    );

    assign take = ack && pick.valid;

    always_comb begin
        clr = '0;
        if (take) clr[pick.idx] = 1'b1;
    end

    irq_inservice u_svc (
        .clk(clk), .rst(rst), .take(take), .take_lvl(pick.level),
        .reti(reti), .svc(in_service)
    );

    assign irq_valid  = pick.valid;
    assign irq_level  = pick.level;
    assign irq_vector = pick.valid ? vec_of(pick.idx) : '0;

    a_r2_global_gate: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !irq_valid);
    a_r9_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
        in_service[1] |-> !irq_valid);
    a_r9_low_only_high: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && in_service[0]) |-> irq_level);
    a_r6_vector_align: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector[2:0] == 3'b011 && irq_vector[15:6] == '0));
    a_r11_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_valid && !reti) |=> (in_service == $past(in_service)));
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [1:0]  ext_n;
    logic [1:0]  tmr_ovf;
    logic        ser_req, t2_req, ack, reti;
    logic        irq_valid, irq_level;
    logic [15:0] irq_vector;
    logic [1:0]  in_service;
    logic [3:0]  flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_ctrl_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_req(ser_req), .t2_req(t2_req), .ack(ack), .reti(reti),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
        .in_service(in_service), .flags(flags)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    // model: returns {valid, level, vector}
    function automatic logic [17:0] model(input logic [7:0] en, input logic [5:0] pri,
                                          input logic [5:0] rq);
        logic [5:0] c, h;
        c = rq & en[5:0] & {6{en[7]}};
        h = c & pri;
        for (int i = 0; i < 6; i++)
            if (h[i]) return {1'b1, 1'b1, 16'h0003 + 16'(8 * i)};
        for (int i = 0; i < 6; i++)
            if (c[i]) return {1'b1, 1'b0, 16'h0003 + 16'(8 * i)};
        return '0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [17:0] e;
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; ext_n = 2'b11;
        tmr_ovf = 0; ser_req = 0; t2_req = 0; ack = 0; reti = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 valid", 16'(irq_valid), 16'd0);
        chk("R1 in_service", 16'(in_service), 16'd0);
        chk("R1 flags", 16'(flags), 16'd0);
        ser_req = 1; t2_req = 1; ext_n = 2'b00; #1;
        chk("R1 enables clear", 16'(irq_valid), 16'd0);
        ser_req = 0; t2_req = 0; ext_n = 2'b11;

        // R2 global gate
        ser_req = 1;
        wr(2'd0, 8'h10); #1;
        chk("R2 gate off", 16'(irq_valid), 16'd0);
        wr(2'd0, 8'h90); #1;
        chk("R2 gate on", 16'(irq_valid), 16'd1);
        chk("R6 serial vector", irq_vector, 16'h0023);

        // R3 individual enable
        t2_req = 1;
        wr(2'd0, 8'hA0); #1;
        chk("R3 only t2 enabled", irq_vector, 16'h002B);
        // R5 poll order
        wr(2'd0, 8'hBF); #1;
        chk("R5 serial before t2", irq_vector, 16'h0023);
        // R4 high level wins
        wr(2'd1, 8'h20); #1;
        chk("R4 high vector", irq_vector, 16'h002B);
        chk("R4 high level", 16'(irq_level), 16'd1);

        // R9 high in service blocks, R8 t2 not cleared, R10 return
        pulse_ack(); #1;
        chk("R9 svc high", 16'(in_service), 16'b10);
        chk("R9 high blocks", 16'(irq_valid), 16'd0);
        pulse_reti(); #1;
        chk("R10 pop high", 16'(in_service), 16'b00);
        chk("R8 t2 persists", irq_vector, 16'h002B);

        // nesting
        t2_req = 0; #1;
        chk("R4 low serial", irq_vector, 16'h0023);
        pulse_ack(); #1;
        chk("R9 svc low", 16'(in_service), 16'b01);
        chk("R9 same level blocked", 16'(irq_valid), 16'd0);
        t2_req = 1; #1;
        chk("R9 high preempts", irq_vector, 16'h002B);
        pulse_ack(); #1;
        chk("R9 svc both", 16'(in_service), 16'b11);
        pulse_reti(); #1;
        chk("R10 high first", 16'(in_service), 16'b01);
        pulse_reti(); #1;
        chk("R10 then low", 16'(in_service), 16'b00);
        ser_req = 0; t2_req = 0;
        wr(2'd1, 8'h00);

        // R7 level mode
        ext_n[0] = 1'b0; #1;
        chk("R7 level follows pin", irq_vector, 16'h0003);
        pulse_ack(); pulse_reti(); #1;
        chk("R8 level not cleared", irq_vector, 16'h0003);
        ext_n[0] = 1'b1; #1;
        chk("R7 level release", 16'(irq_valid), 16'd0);

        // R7 edge mode
        wr(2'd2, 8'h03);
        ext_n[1] = 1'b0;
        tick();
        chk("R7 edge flag set", 16'(flags), 16'b0100);
        ext_n[1] = 1'b1;
        tick();
        chk("R7 edge held", irq_vector, 16'h0013);
        pulse_ack(); #1;
        chk("R8 edge cleared", 16'(flags), 16'b0000);
        pulse_reti();

        // R8 timer flag
        tmr_ovf = 2'b01; tick(); tmr_ovf = 2'b00; #1;
        chk("R8 tf0 set", 16'(flags), 16'b0010);
        chk("R6 timer0 vector", irq_vector, 16'h000B);
        pulse_ack(); #1;
        chk("R8 tf0 cleared", 16'(flags), 16'b0000);
        pulse_reti(); #1;

        // R11 idle ack
        chk("R11 idle", 16'(irq_valid), 16'd0);
        pulse_ack(); #1;
        chk("R11 svc unchanged", 16'(in_service), 16'b00);
        tmr_ovf = 2'b10; tick(); tmr_ovf = 2'b00; #1;
        chk("R6 timer1 vector", irq_vector, 16'h001B);
        pulse_ack(); #1;
        chk("R8 tf1 cleared", 16'(flags), 16'b0000);
        pulse_reti();

        // random phase, level-mode externals
        wr(2'd2, 8'h00);
        for (int n = 0; n < 300; n++) begin
            logic [7:0] en;
            logic [5:0] pr;
            en = 8'($urandom);
            pr = 6'($urandom);
            wr(2'd0, en);
            wr(2'd1, {2'b00, pr});
            ext_n   = 2'($urandom);
            ser_req = 1'($urandom);
            t2_req  = 1'($urandom);
            #1;
            e = model(en, pr, {t2_req, ser_req, 1'b0, !ext_n[1], 1'b0, !ext_n[0]});
            chk("R2 R3 R4 R5 random valid", 16'(irq_valid), 16'(e[17]));
            if (e[17]) begin
                chk("R4 random level", 16'(irq_level), 16'(e[16]));
                chk("R5 R6 random vector", irq_vector, e[15:0]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule